// File: doc/BRIEF.md
# Dual-Clock Mailbox Register Pair

This block carries single-word messages between two ports that run on unrelated clocks, next to a data FIFO that lives outside it. Port A deposits words into the first mailbox and collects words from the second. Port B does the opposite. Each mailbox holds one word. Once a word is written, the writer's free flag drops and stays low until the far port has taken the word. Until then any new write to that mailbox is refused, so no message can be overwritten before it has been read.

Every port operation is qualified by an enable, a direction input and a mailbox select. The direction polarity differs between the ports. When Port B reads, its output path is shared: the select line picks either the first mailbox or the FIFO output word supplied from outside. The flag handshake between the domains uses one toggle bit per side and a two-stage synchronizer in each direction. Each reader also gets an "available" indication in its own clock domain. A master or partial reset returns both flags to the idle state. A separate active-low initialise input clears the word held in the second mailbox.

Top module: `mbox_pair_top`

## Requirements
- R1: Port A writes when `a_dir`=1 and reads when `a_dir`=0. Port B writes when `b_dir`=0 and reads when `b_dir`=1. A mailbox is accessed only when the port's enable and mailbox select are both 1. An access with enable 0 or select 0 leaves every mailbox word and flag unchanged.
- R2: An accepted write stores the word and drives the writer's free flag (`mail1_free` or `mail2_free`) to 0 from that same writer clock edge.
- R3: While a free flag is 0, writes to that mailbox are ignored and the stored word is kept.
- R4: The reader's available flag (`mail1_avail` in the B domain, `mail2_avail` in the A domain) rises two to three reader clocks after a write. A mailbox read while it is 1 clears it at that reader edge. The writer's free flag returns to 1 two to three writer clocks later.
- R5: A FIFO-path read (select 0), or a mailbox read while nothing is available, changes no flag.
- R6: Holding either the master reset or the partial reset low in both domains sets both free flags to 1 and both available flags to 0.
- R7: `mail2_init_n` low at a `clk_b` edge clears the second mailbox word to zero.
- R8: While Port B reads, `b_rdata` shows the first mailbox word when `b_mbox_sel`=1 and `fifo_q` when it is 0. When Port B is not reading, `b_rdata` is zero. While Port A reads with select 1, `a_rdata` shows the second mailbox word. Otherwise `a_rdata` is zero.
- R9: Every accepted word is delivered to the reader exactly once, in write order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| a_mrst_n | input | 1 | Port A master reset, active low, synchronous |
| a_prst_n | input | 1 | Port A partial reset, active low, synchronous |
| a_en | input | 1 | Port A operation enable |
| a_dir | input | 1 | Port A direction: 1 write, 0 read |
| a_mbox_sel | input | 1 | Port A mailbox select |
| a_wdata | input | DATA_W | Word written into the first mailbox |
| a_rdata | output | DATA_W | Second mailbox word as seen by Port A |
| mail1_free | output | 1 | First mailbox can accept a write (clk_a domain) |
| mail2_avail | output | 1 | Second mailbox holds an unread word (clk_a domain) |
| clk_b | input | 1 | Port B clock |
| b_mrst_n | input | 1 | Port B master reset, active low, synchronous |
| b_prst_n | input | 1 | Port B partial reset, active low, synchronous |
| mail2_init_n | input | 1 | Clears the second mailbox word, active low (clk_b domain) |
| b_en | input | 1 | Port B operation enable |
| b_dir | input | 1 | Port B direction: 0 write, 1 read |
| b_mbox_sel | input | 1 | Port B mailbox select / output source select |
| b_wdata | input | DATA_W | Word written into the second mailbox |
| fifo_q | input | DATA_W | FIFO output register word, muxed onto b_rdata |
| b_rdata | output | DATA_W | Port B read data |
| mail2_free | output | 1 | Second mailbox can accept a write (clk_b domain) |
| mail1_avail | output | 1 | First mailbox holds an unread word (clk_b domain) |

## Verification
The hardest case to reach is a second write that arrives while the earlier word is still unread in the other domain, together with reads on the far side that must leave the flags alone. The bench issues a conflicting write on the writer clock directly after each accepted write. With clock periods of 8 ns and 13 ns, that write always falls inside the synchronizer window. On the reader side it slips in a FIFO-path read and an idle mailbox read while a word is pending. The scoreboard then shows that only the first word arrives, exactly once. A partial reset with a word still pending covers flag recovery when nothing was read.

// File: rtl/mbox_pkg.sv
`timescale 1ns/1ps
// Shared constants for the mailbox pair.
// Assumes: every crossing signal is a single toggle bit.
package mbox_pkg;
    localparam int unsigned MBOX_DATA_W   = 36;
    localparam int unsigned MBOX_SYNC_LEN = 2;

    // Direction level that means "write" on each port
    localparam logic PORT_A_WRITE_LVL = 1'b1;
    localparam logic PORT_B_WRITE_LVL = 1'b0;

    typedef struct packed {
        logic mb_wr;
        logic mb_rd;
        logic drive;
    } port_op_t;
endpackage

// File: rtl/mbox_sync.sv
`timescale 1ns/1ps
// Multi-stage synchronizer for one slowly changing bit (a toggle).
// Assumes: d changes at most once per several destination clocks.
module mbox_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    // Shift the asynchronous bit through the stage chain
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/mbox_port_dec.sv
`timescale 1ns/1ps
// Decodes enable, direction and mailbox select of one port into
// mailbox write / read strobes and an output-drive indication.
// Assumes: WRITE_LVL gives the direction level that means write.
module mbox_port_dec
    import mbox_pkg::*;
#(
    parameter logic WRITE_LVL = 1'b1
) (
    input  logic     en,
    input  logic     dir,
    input  logic     sel,
    output port_op_t op
);
    logic is_wr;

    generate
        if (WRITE_LVL) begin : g_wr_high
            assign is_wr = dir;
        end else begin : g_wr_low
            assign is_wr = ~dir;
        end
    endgenerate

    // Form the strobes; drive follows the read direction regardless of enable
    always_comb begin
        op.drive = ~is_wr;
        op.mb_wr = en & sel & is_wr;
        op.mb_rd = en & sel & ~is_wr;
    end
endmodule

// File: rtl/mbox_wr_side.sv
`timescale 1ns/1ps
// Writer half of one mailbox: holds the word, flips a toggle on each
// accepted write and compares it with the synchronized reader toggle
// to produce the free flag.
// Assumes: flag_rst_n is held in the reader domain at the same time.
module mbox_wr_side
    import mbox_pkg::*;
#(
    parameter int unsigned DATA_W = MBOX_DATA_W,
    parameter int unsigned SYNC_N = MBOX_SYNC_LEN
) (
    input  logic              clk,
    input  logic              flag_rst_n,
    input  logic              clr_n,
    input  logic              wr_req,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rd_tog_async,
    output logic [DATA_W-1:0] data_q,
    output logic              wr_tog,
    output logic              free
);
    logic rd_tog_s;
    logic accept;

    mbox_sync #(.STAGES(SYNC_N)) u_sync (
        .clk   (clk),
        .rst_n (flag_rst_n),
        .d     (rd_tog_async),
        .q     (rd_tog_s)
    );

    assign free   = ~(wr_tog ^ rd_tog_s);
    assign accept = wr_req & free;

    // Flip the write toggle on every accepted write
    always_ff @(posedge clk) begin
        if (!flag_rst_n)  wr_tog <= 1'b0;
        else if (accept)  wr_tog <= ~wr_tog;
    end

    // Capture the word on acceptance; clear on initialise
    always_ff @(posedge clk) begin
        if (!clr_n)       data_q <= '0;
        else if (accept)  data_q <= wdata;
    end

    // R2: an accepted write leaves the flag low
    a_r2_flag_drops: assert property (@(posedge clk) disable iff (!flag_rst_n)
        (wr_req && free) |=> !free);

    // R3: a refused write keeps the stored word
    a_r3_word_held: assert property (@(posedge clk) disable iff (!flag_rst_n || !clr_n)
        (wr_req && !free) |=> $stable(data_q));

    // R6: reset returns the flag to free
    a_r6_reset_frees: assert property (@(posedge clk)
        !flag_rst_n |=> free);
endmodule

// File: rtl/mbox_rd_side.sv
`timescale 1ns/1ps
// Reader half of one mailbox: synchronizes the writer toggle, reports
// an unread word and flips its own toggle when that word is taken.
// Assumes: the writer never toggles again before this side answers.
module mbox_rd_side
    import mbox_pkg::*;
#(
    parameter int unsigned SYNC_N = MBOX_SYNC_LEN
) (
    input  logic clk,
    input  logic flag_rst_n,
    input  logic rd_req,
    input  logic wr_tog_async,
    output logic rd_tog,
    output logic avail
);
    logic wr_tog_s;

    mbox_sync #(.STAGES(SYNC_N)) u_sync (
        .clk   (clk),
        .rst_n (flag_rst_n),
        .d     (wr_tog_async),
        .q     (wr_tog_s)
    );

    assign avail = wr_tog_s ^ rd_tog;

    // Flip the read toggle when a pending word is consumed
    always_ff @(posedge clk) begin
        if (!flag_rst_n)          rd_tog <= 1'b0;
        else if (rd_req && avail) rd_tog <= ~rd_tog;
    end

    // R4: a read of a pending word clears availability at once
    a_r4_read_clears: assert property (@(posedge clk) disable iff (!flag_rst_n)
        (rd_req && avail) |=> !avail);

    // R5: without a mailbox read, a pending word stays pending
    a_r5_pending_kept: assert property (@(posedge clk) disable iff (!flag_rst_n)
        (!rd_req && avail) |=> avail);

    // R6: reset leaves nothing available
    a_r6_reset_empty: assert property (@(posedge clk)
        !flag_rst_n |=> !avail);
endmodule

// File: rtl/mbox_pair_top.sv
`timescale 1ns/1ps
// Two one-word mailboxes between unrelated clocks, plus the Port B
// output mux shared with the FIFO output register.
// Assumes: master/partial resets are asserted in both domains together
// for several clocks of each.
module mbox_pair_top
    import mbox_pkg::*;
#(
    parameter int unsigned DATA_W = MBOX_DATA_W,
    parameter int unsigned SYNC_N = MBOX_SYNC_LEN
) (
    input  logic              clk_a,
    input  logic              a_mrst_n,
    input  logic              a_prst_n,
    input  logic              a_en,
    input  logic              a_dir,
    input  logic              a_mbox_sel,
    input  logic [DATA_W-1:0] a_wdata,
    output logic [DATA_W-1:0] a_rdata,
    output logic              mail1_free,
    output logic              mail2_avail,
    input  logic              clk_b,
    input  logic              b_mrst_n,
    input  logic              b_prst_n,
    input  logic              mail2_init_n,
    input  logic              b_en,
    input  logic              b_dir,
    input  logic              b_mbox_sel,
    input  logic [DATA_W-1:0] b_wdata,
    input  logic [DATA_W-1:0] fifo_q,
    output logic [DATA_W-1:0] b_rdata,
    output logic              mail2_free,
    output logic              mail1_avail
);
    port_op_t          op_a, op_b;
    logic              frst_a_n, frst_b_n;
    logic [DATA_W-1:0] mail1_q, mail2_q;
    logic              m1_wtog, m1_rtog, m2_wtog, m2_rtog;

    assign frst_a_n = a_mrst_n & a_prst_n;
    assign frst_b_n = b_mrst_n & b_prst_n;

    mbox_port_dec #(.WRITE_LVL(PORT_A_WRITE_LVL)) u_dec_a (
        .en (a_en), .dir (a_dir), .sel (a_mbox_sel), .op (op_a)
    );

    mbox_port_dec #(.WRITE_LVL(PORT_B_WRITE_LVL)) u_dec_b (
        .en (b_en), .dir (b_dir), .sel (b_mbox_sel), .op (op_b)
    );

    // First mailbox: written on clk_a, read on clk_b
    mbox_wr_side #(.DATA_W(DATA_W), .SYNC_N(SYNC_N)) u_m1_wr (
        .clk          (clk_a),
        .flag_rst_n   (frst_a_n),
        .clr_n        (1'b1),
        .wr_req       (op_a.mb_wr),
        .wdata        (a_wdata),
        .rd_tog_async (m1_rtog),
        .data_q       (mail1_q),
        .wr_tog       (m1_wtog),
        .free         (mail1_free)
    );

    mbox_rd_side #(.SYNC_N(SYNC_N)) u_m1_rd (
        .clk          (clk_b),
        .flag_rst_n   (frst_b_n),
        .rd_req       (op_b.mb_rd),
        .wr_tog_async (m1_wtog),
        .rd_tog       (m1_rtog),
        .avail        (mail1_avail)
    );

    // Second mailbox: written on clk_b, read on clk_a
    mbox_wr_side #(.DATA_W(DATA_W), .SYNC_N(SYNC_N)) u_m2_wr (
        .clk          (clk_b),
        .flag_rst_n   (frst_b_n),
        .clr_n        (mail2_init_n),
        .wr_req       (op_b.mb_wr),
        .wdata        (b_wdata),
        .rd_tog_async (m2_rtog),
        .data_q       (mail2_q),
        .wr_tog       (m2_wtog),
        .free         (mail2_free)
    );

    mbox_rd_side #(.SYNC_N(SYNC_N)) u_m2_rd (
        .clk          (clk_a),
        .flag_rst_n   (frst_a_n),
        .rd_req       (op_a.mb_rd),
        .wr_tog_async (m2_wtog),
        .rd_tog       (m2_rtog),
        .avail        (mail2_avail)
    );

    // Port A read data: second mailbox word while reading it
    always_comb begin
        a_rdata = (op_a.drive && a_mbox_sel) ? mail2_q : '0;
    end

    // Port B read data: mailbox or FIFO word while reading, else zero
    always_comb begin
        if (!op_b.drive)     b_rdata = '0;
        else if (b_mbox_sel) b_rdata = mail1_q;
        else                 b_rdata = fifo_q;
    end
endmodule

// File: tb/sim_mbox_pair_top.sv
`timescale 1ns/1ps
module sim_mbox_pair_top;
    localparam int W = 36;

    logic clk_a = 1'b0, clk_b = 1'b0;
    always #4    clk_a = ~clk_a;   // 125 MHz
    always #6.5  clk_b = ~clk_b;   // unrelated

    logic a_mrst_n = 1'b0, a_prst_n = 1'b1, a_en = 1'b0, a_dir = 1'b0, a_mbox_sel = 1'b0;
    logic b_mrst_n = 1'b0, b_prst_n = 1'b1, mail2_init_n = 1'b0;
    logic b_en = 1'b0, b_dir = 1'b1, b_mbox_sel = 1'b0;
    logic [W-1:0] a_wdata = '0, b_wdata = '0, fifo_q = 36'h0_5A5A_0001;
    logic [W-1:0] a_rdata, b_rdata;
    logic mail1_free, mail2_avail, mail2_free, mail1_avail;

    mbox_pair_top #(.DATA_W(W)) u0 (
        .clk_a(clk_a), .a_mrst_n(a_mrst_n), .a_prst_n(a_prst_n), .a_en(a_en),
        .a_dir(a_dir), .a_mbox_sel(a_mbox_sel), .a_wdata(a_wdata), .a_rdata(a_rdata),
        .mail1_free(mail1_free), .mail2_avail(mail2_avail),
        .clk_b(clk_b), .b_mrst_n(b_mrst_n), .b_prst_n(b_prst_n),
        .mail2_init_n(mail2_init_n), .b_en(b_en), .b_dir(b_dir),
        .b_mbox_sel(b_mbox_sel), .b_wdata(b_wdata), .fifo_q(fifo_q),
        .b_rdata(b_rdata), .mail2_free(mail2_free), .mail1_avail(mail1_avail)
    );

    int n_cmp = 0, n_bad = 0;
    logic [W-1:0] q1[$];
    logic [W-1:0] q2[$];

    task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    // Driver: one word into the first mailbox, then a write that must be refused
    task automatic a_write1(input logic [W-1:0] d);
        @(negedge clk_a);
        while (!mail1_free) @(negedge clk_a);
        a_en = 1'b1; a_dir = 1'b1; a_mbox_sel = 1'b1; a_wdata = d;
        q1.push_back(d);
        @(negedge clk_a);
        chk(!mail1_free, "R2 mail1_free after write", W'(mail1_free), W'(0));
        a_wdata = ~d;                       // R3: refused, flag still low
        @(negedge clk_a);
        a_en = 1'b0;
    endtask

    // Driver: one word into the second mailbox, then a refused write
    task automatic b_write2(input logic [W-1:0] d);
        @(negedge clk_b);
        while (!mail2_free) @(negedge clk_b);
        b_en = 1'b1; b_dir = 1'b0; b_mbox_sel = 1'b1; b_wdata = d;
        q2.push_back(d);
        @(negedge clk_b);
        chk(!mail2_free, "R2 mail2_free after write", W'(mail2_free), W'(0));
        chk(b_rdata == '0, "R8 b_rdata while writing", b_rdata, '0);
        b_wdata = ~d;                       // R3: refused
        @(negedge clk_b);
        b_en = 1'b0;
    endtask

    initial begin
        repeat (50000) @(posedge clk_a);
        n_cmp++; n_bad++;
        $display("FAIL R9 watchdog actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        // Master reset in both domains, second mailbox initialised
        repeat (4) @(negedge clk_b);
        b_mrst_n = 1'b1; mail2_init_n = 1'b1;
        @(negedge clk_a);
        a_mrst_n = 1'b1;
        @(negedge clk_a);
        chk(mail1_free,   "R6 mail1_free after reset",  W'(mail1_free),  W'(1));
        chk(!mail2_avail, "R6 mail2_avail after reset", W'(mail2_avail), W'(0));
        a_dir = 1'b0; a_mbox_sel = 1'b1;
        #1 chk(a_rdata == '0, "R7 mail2 word after init", a_rdata, '0);
        @(negedge clk_b);
        chk(mail2_free,   "R6 mail2_free after reset",  W'(mail2_free),  W'(1));
        chk(!mail1_avail, "R6 mail1_avail after reset", W'(mail1_avail), W'(0));
        b_dir = 1'b1; b_mbox_sel = 1'b0;
        #1 chk(b_rdata == fifo_q, "R8 FIFO path on b_rdata", b_rdata, fifo_q);

        // R1: write without enable / with select low does nothing
        @(negedge clk_a);
        a_dir = 1'b1; a_mbox_sel = 1'b1; a_en = 1'b0; a_wdata = 36'h0DEAD;
        @(negedge clk_a);
        a_mbox_sel = 1'b0; a_en = 1'b1;
        @(negedge clk_a);
        a_en = 1'b0;
        @(negedge clk_a);
        chk(mail1_free, "R1 no write without enable/select", W'(mail1_free), W'(1));
        repeat (4) @(negedge clk_b);
        chk(!mail1_avail, "R1 nothing arrived at port B", W'(mail1_avail), W'(0));

        // R5: mailbox read while empty changes nothing
        b_mbox_sel = 1'b1; b_en = 1'b1;
        @(negedge clk_b);
        b_en = 1'b0;
        repeat (4) @(negedge clk_b);
        chk(!mail1_avail, "R5 empty read keeps avail", W'(mail1_avail), W'(0));
        @(negedge clk_a);
        chk(mail1_free, "R5 empty read keeps free", W'(mail1_free), W'(1));

        // Phase 1: A -> B through the first mailbox
        fork
            begin
                for (int i = 0; i < 12; i++) a_write1(36'h1_2300_0000 + 36'(i * 4097));
            end
            begin
                int got = 0;
                b_dir = 1'b1; b_mbox_sel = 1'b1;
                while (got < 12) begin
                    @(negedge clk_b);
                    if (mail1_avail) begin
                        chk(b_rdata == q1[0], "R9 mail1 word order", b_rdata, q1[0]);
                        if (got == 3) begin
                            b_mbox_sel = 1'b0; b_en = 1'b1;   // FIFO-path read
                            @(negedge clk_b);
                            b_en = 1'b0; b_mbox_sel = 1'b1;
                            chk(mail1_avail, "R5 FIFO read keeps avail", W'(mail1_avail), W'(1));
                        end
                        b_en = 1'b1;
                        @(negedge clk_b);
                        b_en = 1'b0;
                        void'(q1.pop_front());
                        got++;
                        chk(!mail1_avail, "R4 read clears mail1_avail", W'(mail1_avail), W'(0));
                    end else begin
                        fifo_q = fifo_q + 36'h1_0101;
                        b_mbox_sel = 1'b0;
                        #1 chk(b_rdata == fifo_q, "R8 FIFO mux", b_rdata, fifo_q);
                        b_mbox_sel = 1'b1;
                    end
                end
            end
        join
        chk(q1.size() == 0, "R9 mail1 all read once", W'(q1.size()), W'(0));
        repeat (4) @(negedge clk_a);
        chk(mail1_free, "R4 mail1_free restored", W'(mail1_free), W'(1));

        // Phase 2: B -> A through the second mailbox
        fork
            begin
                for (int i = 0; i < 8; i++) b_write2(36'h8_0000_00F0 + 36'(i * 257));
            end
            begin
                int got = 0;
                a_dir = 1'b0; a_mbox_sel = 1'b1;
                while (got < 8) begin
                    @(negedge clk_a);
                    if (mail2_avail) begin
                        chk(a_rdata == q2[0], "R9 mail2 word order", a_rdata, q2[0]);
                        a_en = 1'b1;
                        @(negedge clk_a);
                        a_en = 1'b0;
                        void'(q2.pop_front());
                        got++;
                        chk(!mail2_avail, "R4 read clears mail2_avail", W'(mail2_avail), W'(0));
                    end
                end
            end
        join
        chk(q2.size() == 0, "R9 mail2 all read once", W'(q2.size()), W'(0));
        repeat (4) @(negedge clk_b);
        chk(mail2_free, "R4 mail2_free restored", W'(mail2_free), W'(1));

        // R7: initialise clears the second mailbox word
        b_dir = 1'b1; b_mbox_sel = 1'b0;
        mail2_init_n = 1'b0;
        @(negedge clk_b);
        mail2_init_n = 1'b1;
        @(negedge clk_a);
        a_dir = 1'b0; a_mbox_sel = 1'b1; a_en = 1'b0;
        #1 chk(a_rdata == '0, "R7 mail2 word cleared", a_rdata, '0);

        // R6: partial reset with an unread word pending
        a_write1(36'h7_7777_0001);
        repeat (5) @(negedge clk_b);
        chk(mail1_avail, "R4 pending word visible", W'(mail1_avail), W'(1));
        @(negedge clk_a);
        a_prst_n = 1'b0;
        @(negedge clk_b);
        b_prst_n = 1'b0;
        repeat (4) @(negedge clk_b);
        b_prst_n = 1'b1;
        @(negedge clk_a);
        a_prst_n = 1'b1;
        @(negedge clk_a);
        chk(mail1_free, "R6 partial reset frees mail1", W'(mail1_free), W'(1));
        @(negedge clk_b);
        chk(!mail1_avail, "R6 partial reset empties mail1", W'(mail1_avail), W'(0));
        q1.delete();

        summary();
        $finish;
    end
endmodule